// File: doc/BRIEF.md
# Miss Response Target Release Unit

This block holds the targets waiting on one outstanding cache miss, split between a primary queue and a deferred queue. When a fill response arrives, it picks the primary targets that the response may serve and hands them out one per cycle on a valid/ready stream. Each handed-out target carries its source tag and order number. A response that carries an invalidation serves only the head target and every snoop target. The remaining CPU targets stay behind in their original order so that they can issue a fresh request later.

After the stream drains, the unit moves deferred targets forward into the primary queue. It stops at the first cache-maintenance request. It then refreshes the entry's order number and ready time from the new head. A separate writable-response strobe moves all deferred targets forward at once when they were held back only because they wanted write permission. The surrounding entry logic fills both queues through a push port and supplies the post-invalidate and post-downgrade state and the current time.

Top module: `miss_release_unit`

## Requirements
- R1: After reset both queue counts, `rel_valid`, `busy`, both needs-writable flags, `entry_order` and `entry_ready` are zero.
- R2: In idle with no strobe, a push appends one target to the tail of the primary queue (`push_defer`=0) or of the deferred queue (`push_defer`=1). When the two queues together already hold DEPTH targets, the push is ignored. Source codes are: 0 = CPU, 1 = prefetcher, 2 = snoop.
- R3: A response with `rsp_inv`=0 releases every primary target in queue order, one per `rel_valid`&&`rel_ready` cycle. While `rel_ready` is low, `rel_valid`, `rel_order` and `rel_src` hold steady.
- R4: A response with `rsp_inv`=1 releases, in queue order, the head target and every target whose source is 2 (snoop). The other targets stay in the primary queue in their original order.
- R5: `prim_nw` and `defer_nw` are the OR of the needs-writable bit over the non-snoop targets in each queue. Both are recomputed after an extraction and after a promotion.
- R6: After the stream ends, deferred targets ahead of the first cache-maintenance target (all of them if there is none) are appended behind the remaining primary targets in order. When both queues are empty, nothing changes, including `entry_order` and `entry_ready`.
- R7: When the deferred head is a cache-maintenance target, that target alone is promoted, and only if the primary queue is empty. Otherwise no target moves.
- R8: After a promotion step with any target present, `entry_order` is the new head's order and `entry_ready` is the later of `now` and the head's ready time.
- R9: A writable strobe with `defer_nw`=1, `post_inv`=0 and `post_dgr`=0 appends all deferred targets behind the primary ones, sets `prim_nw` and clears `defer_nw`. Under any other condition it has no effect.
- R10: While `busy` is high, responses, writable strobes and pushes are ignored. In idle, a response takes priority over a writable strobe, and a writable strobe takes priority over a push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Append one target |
| push_defer | input | 1 | 1 selects the deferred queue |
| push_src | input | 2 | Source code of the pushed target |
| push_cmo | input | 1 | Pushed target is a cache-maintenance request |
| push_nw | input | 1 | Pushed target needs a writable copy |
| push_order | input | ORD_W | Order number of the pushed target |
| push_ready_time | input | TIME_W | Ready time of the pushed target |
| rsp_valid | input | 1 | Fill response arrived |
| rsp_inv | input | 1 | The response carries an invalidation |
| wr_valid | input | 1 | A writable response arrived |
| post_inv | input | 1 | Entry has a pending invalidate |
| post_dgr | input | 1 | Entry has a pending downgrade |
| now | input | TIME_W | Current time |
| rel_valid | output | 1 | A released target is offered |
| rel_ready | input | 1 | Consumer takes the offered target |
| rel_src | output | 2 | Source code of the offered target |
| rel_order | output | ORD_W | Order number of the offered target |
| busy | output | 1 | Stream or promotion in progress |
| prim_count | output | CW | Targets in the primary queue |
| defer_count | output | CW | Targets in the deferred queue |
| prim_nw | output | 1 | Primary needs-writable summary |
| defer_nw | output | 1 | Deferred needs-writable summary |
| entry_order | output | ORD_W | Entry order after the last promotion |
| entry_ready | output | TIME_W | Entry ready time after the last promotion |

## Verification
The assertions assume that the entry never presents an invalidating response whose head target is a snoop. They also assume that the consumer of the stream does not rely on targets being accepted while `busy` is low. The stimulus always pushes a CPU or prefetcher target first into the primary queue, and it issues strobes only after `busy` has fallen. The stall test holds `rel_ready` low on purpose to exercise the hold rule, and it pushes during that stall to confirm the push is ignored.

// File: rtl/mru_pkg.sv
package mru_pkg;
  localparam int ORD_W  = 8;
  localparam int TIME_W = 16;

  typedef enum logic [1:0] {
    SRC_CPU   = 2'd0,
    SRC_PF    = 2'd1,
    SRC_SNOOP = 2'd2
  } src_e;

  typedef struct packed {
    src_e              src;
    logic              cmo;
    logic              nw;
    logic [ORD_W-1:0]  ord;
    logic [TIME_W-1:0] rdy;
  } tgt_t;

  // snoop targets never contribute to the writable summary
  function automatic logic wants_writable(tgt_t t);
    return t.nw && (t.src != SRC_SNOOP);
  endfunction

  function automatic logic [TIME_W-1:0] later_time(logic [TIME_W-1:0] a,
                                                   logic [TIME_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  // a target leaves on a response if it is the head, or if the response
  // does not invalidate, or if it came from a snoop
  function automatic logic leaves_on_rsp(logic inv, logic is_head, tgt_t t);
    return !inv || is_head || (t.src == SRC_SNOOP);
  endfunction
endpackage

// File: rtl/mru_split.sv
module mru_split
  import mru_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  tgt_t          q_in   [DEPTH],
  input  logic [CW-1:0] q_cnt,
  input  logic          inv,
  output tgt_t          rel    [DEPTH],
  output logic [CW-1:0] rel_cnt,
  output tgt_t          keep   [DEPTH],
  output logic [CW-1:0] keep_cnt,
  output logic          keep_nw
);
  int ri;
  int ki;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rel[i]  = '0;
      keep[i] = '0;
    end
    ri = 0;
    ki = 0;
    keep_nw = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(q_cnt)) begin
        if (leaves_on_rsp(inv, i == 0, q_in[i])) begin
          rel[IW'(ri)] = q_in[i];
          ri = ri + 1;
        end else begin
          keep[IW'(ki)] = q_in[i];
          ki = ki + 1;
          keep_nw = keep_nw | wants_writable(q_in[i]);
        end
      end
    end
    rel_cnt  = CW'(ri);
    keep_cnt = CW'(ki);
  end
endmodule

// File: rtl/mru_promote_sel.sv
module mru_promote_sel
  import mru_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  tgt_t          dq     [DEPTH],
  input  logic [CW-1:0] d_cnt,
  input  logic [CW-1:0] p_cnt,
  output logic [CW-1:0] take
);
  logic [CW-1:0] first_cmo;

  always_comb begin
    first_cmo = d_cnt;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if ((i < int'(d_cnt)) && dq[i].cmo) first_cmo = CW'(i);
    end
    if (d_cnt == '0)
      take = '0;
    else if (first_cmo == '0)
      take = (p_cnt == '0) ? CW'(1) : '0;
    else
      take = first_cmo;
  end
endmodule

// File: rtl/miss_release_unit.sv
module miss_release_unit
  import mru_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic              push_defer,
  input  logic [1:0]        push_src,
  input  logic              push_cmo,
  input  logic              push_nw,
  input  logic [ORD_W-1:0]  push_order,
  input  logic [TIME_W-1:0] push_ready_time,
  input  logic              rsp_valid,
  input  logic              rsp_inv,
  input  logic              wr_valid,
  input  logic              post_inv,
  input  logic              post_dgr,
  input  logic [TIME_W-1:0] now,
  output logic              rel_valid,
  input  logic              rel_ready,
  output logic [1:0]        rel_src,
  output logic [ORD_W-1:0]  rel_order,
  output logic              busy,
  output logic [CW-1:0]     prim_count,
  output logic [CW-1:0]     defer_count,
  output logic              prim_nw,
  output logic              defer_nw,
  output logic [ORD_W-1:0]  entry_order,
  output logic [TIME_W-1:0] entry_ready
);
  typedef enum logic [1:0] {ST_IDLE, ST_STREAM, ST_PROMOTE} state_e;

  state_e        state;
  tgt_t          pq   [DEPTH];
  tgt_t          dq   [DEPTH];
  tgt_t          relq [DEPTH];
  logic [CW-1:0] pcnt, dcnt, rcnt;
  logic [IW-1:0] rptr;
  logic          inv_mode;

  // split of the primary queue on a response
  tgt_t          sp_rel  [DEPTH];
  tgt_t          sp_keep [DEPTH];
  logic [CW-1:0] sp_rel_cnt, sp_keep_cnt;
  logic          sp_keep_nw;

  mru_split #(.DEPTH(DEPTH)) u_split (
    .q_in(pq), .q_cnt(pcnt), .inv(rsp_inv),
    .rel(sp_rel), .rel_cnt(sp_rel_cnt),
    .keep(sp_keep), .keep_cnt(sp_keep_cnt), .keep_nw(sp_keep_nw)
  );

  logic [CW-1:0] prom_take;

  mru_promote_sel #(.DEPTH(DEPTH)) u_psel (
    .dq(dq), .d_cnt(dcnt), .p_cnt(pcnt), .take(prom_take)
  );

  // named events
  logic [CW:0]   total;
  logic          rsp_fire, wr_fire, push_fire, prom_fire, rel_fire, last_rel;
  assign total     = {1'b0, pcnt} + {1'b0, dcnt};
  assign rsp_fire  = (state == ST_IDLE) && rsp_valid;
  assign wr_fire   = (state == ST_IDLE) && !rsp_valid && wr_valid &&
                     defer_nw && !post_inv && !post_dgr;
  assign push_fire = (state == ST_IDLE) && !rsp_valid && !wr_valid &&
                     push_valid && (total < (CW+1)'(DEPTH));
  assign prom_fire = (state == ST_PROMOTE);
  assign rel_fire  = rel_valid && rel_ready;
  assign last_rel  = (CW'(rptr) + CW'(1)) == rcnt;

  // shared append: move n_sel deferred targets behind the primary ones
  logic [CW-1:0] n_sel;
  tgt_t          pq_app  [DEPTH];
  tgt_t          dq_rest [DEPTH];
  logic          app_p_nw, app_d_nw;
  assign n_sel = wr_fire ? dcnt : prom_take;

  always_comb begin
    app_p_nw = 1'b0;
    app_d_nw = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      pq_app[i]  = '0;
      dq_rest[i] = '0;
      if (i < int'(pcnt))
        pq_app[i] = pq[i];
      else if ((i - int'(pcnt)) < int'(n_sel))
        pq_app[i] = dq[IW'(i - int'(pcnt))];
      if ((i + int'(n_sel)) < int'(dcnt))
        dq_rest[i] = dq[IW'(i + int'(n_sel))];
      app_p_nw = app_p_nw | wants_writable(pq_app[i]);
      app_d_nw = app_d_nw | wants_writable(dq_rest[i]);
    end
  end

  tgt_t push_tgt;
  assign push_tgt = '{src: src_e'(push_src), cmo: push_cmo, nw: push_nw,
                      ord: push_order, rdy: push_ready_time};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      pcnt        <= '0;
      dcnt        <= '0;
      rcnt        <= '0;
      rptr        <= '0;
      inv_mode    <= 1'b0;
      prim_nw     <= 1'b0;
      defer_nw    <= 1'b0;
      entry_order <= '0;
      entry_ready <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        pq[i]   <= '0;
        dq[i]   <= '0;
        relq[i] <= '0;
      end
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (rsp_fire) begin
            relq     <= sp_rel;
            rcnt     <= sp_rel_cnt;
            pq       <= sp_keep;
            pcnt     <= sp_keep_cnt;
            prim_nw  <= sp_keep_nw;
            rptr     <= '0;
            inv_mode <= rsp_inv;
            state    <= (sp_rel_cnt != '0) ? ST_STREAM : ST_PROMOTE;
          end else if (wr_fire) begin
            pq       <= pq_app;
            dq       <= dq_rest;
            pcnt     <= pcnt + dcnt;
            dcnt     <= '0;
            prim_nw  <= 1'b1;
            defer_nw <= 1'b0;
          end else if (push_fire) begin
            if (push_defer) begin
              dq[dcnt[IW-1:0]] <= push_tgt;
              dcnt     <= dcnt + CW'(1);
              defer_nw <= defer_nw | wants_writable(push_tgt);
            end else begin
              pq[pcnt[IW-1:0]] <= push_tgt;
              pcnt    <= pcnt + CW'(1);
              prim_nw <= prim_nw | wants_writable(push_tgt);
            end
          end
        end
        ST_STREAM: begin
          if (rel_fire) begin
            rptr <= rptr + IW'(1);
            if (last_rel) state <= ST_PROMOTE;
          end
        end
        ST_PROMOTE: begin
          if ((pcnt != '0) || (dcnt != '0)) begin
            pq          <= pq_app;
            dq          <= dq_rest;
            pcnt        <= pcnt + prom_take;
            dcnt        <= dcnt - prom_take;
            prim_nw     <= app_p_nw;
            defer_nw    <= app_d_nw;
            entry_order <= pq_app[0].ord;
            entry_ready <= later_time(now, pq_app[0].rdy);
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rel_valid   = (state == ST_STREAM);
  assign rel_src     = relq[rptr].src;
  assign rel_order   = relq[rptr].ord;
  assign busy        = (state != ST_IDLE);
  assign prim_count  = pcnt;
  assign defer_count = dcnt;

  // ---------------- assertions ----------------
  assert_capacity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    total <= (CW+1)'(DEPTH));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && !rel_ready |=> rel_valid && $stable(rel_order) && $stable(rel_src));

  assert_inv_snoop_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && inv_mode && (rptr != '0) |-> rel_src == SRC_SNOOP);

  assert_ready_not_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prom_fire && ((pcnt != '0) || (dcnt != '0)) |=> entry_ready >= $past(now));

  assert_writable_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (defer_count == '0) && prim_nw && !defer_nw);

  assert_busy_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |=> $stable(defer_count));
endmodule

// File: tb/miss_release_unit_tb.sv
module miss_release_unit_tb;
  import mru_pkg::*;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 0, push_defer = 0, push_cmo = 0, push_nw = 0;
  logic [1:0] push_src = 0;
  logic [ORD_W-1:0] push_order = 0;
  logic [TIME_W-1:0] push_ready_time = 0, now = 0;
  logic rsp_valid = 0, rsp_inv = 0, wr_valid = 0, post_inv = 0, post_dgr = 0;
  logic rel_ready = 1'b1;
  logic rel_valid, busy, prim_nw, defer_nw;
  logic [1:0] rel_src;
  logic [ORD_W-1:0] rel_order, entry_order;
  logic [TIME_W-1:0] entry_ready;
  logic [CW-1:0] prim_count, defer_count;

  always #4 clk = ~clk;

  miss_release_unit #(.DEPTH(DEPTH)) u_dut (.*);

  int checks = 0, fails = 0;
  int got_ord [16];
  int got_src [16];
  int got_n;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(bit d, int s, bit c, bit w, int o, int r);
    @(negedge clk);
    push_valid = 1; push_defer = d; push_src = 2'(s); push_cmo = c;
    push_nw = w; push_order = ORD_W'(o); push_ready_time = TIME_W'(r);
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic respond(bit inv);
    @(negedge clk);
    rsp_valid = 1; rsp_inv = inv;
    @(negedge clk);
    rsp_valid = 0; rsp_inv = 0;
  endtask

  task automatic drain();
    got_n = 0;
    rel_ready = 1;
    while (busy) begin
      if (rel_valid && got_n < 16) begin
        got_ord[got_n] = int'(rel_order);
        got_src[got_n] = int'(rel_src);
        got_n++;
      end
      @(negedge clk);
    end
  endtask

  // {inv, expected release mask (bit i = target i), sources {s3,s2,s1,s0}}
  localparam logic [12:0] VEC [7] = '{
    {1'b0, 4'b1111, 8'b00000000},
    {1'b1, 4'b0001, 8'b00000000},
    {1'b1, 4'b1011, 8'b10001001},
    {1'b1, 4'b0101, 8'b00100000},
    {1'b1, 4'b1111, 8'b10101000},
    {1'b0, 4'b1111, 8'b00001001},
    {1'b1, 4'b1001, 8'b10000001}
  };

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 prim_count", int'(prim_count), 0);
    chk("R1 defer_count", int'(defer_count), 0);
    chk("R1 rel_valid", int'(rel_valid), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 flags", int'({prim_nw, defer_nw}), 0);
    chk("R1 entry", int'(entry_order) + int'(entry_ready), 0);

    // table walk: R3 / R4 release selection and leftover order
    for (int v = 0; v < 7; v++) begin
      logic inv; logic [3:0] m; logic [7:0] s; int k;
      {inv, m, s} = VEC[v];
      for (int i = 0; i < 4; i++) push(0, int'(s[2*i +: 2]), 0, 0, v*16 + i, 0);
      respond(inv);
      drain();
      k = 0;
      for (int i = 0; i < 4; i++) if (m[i]) begin
        chk(inv ? "R4 order" : "R3 order", got_ord[k], v*16 + i);
        chk(inv ? "R4 src" : "R3 src", got_src[k], int'(s[2*i +: 2]));
        k++;
      end
      chk(inv ? "R4 count" : "R3 count", got_n, k);
      respond(0);
      drain();
      k = 0;
      for (int i = 0; i < 4; i++) if (!m[i]) begin
        chk("R4 leftover order", got_ord[k], v*16 + i);
        k++;
      end
      chk("R4 leftover count", got_n, k);
    end

    // R2 capacity
    for (int i = 0; i < 9; i++) push(0, 0, 0, 0, 100 + i, 0);
    chk("R2 full ignore", int'(prim_count), 8);
    respond(0); drain();
    chk("R2 drained count", got_n, 8);
    chk("R2 last order", got_ord[7], 107);
    push(1, 0, 0, 0, 1, 0);
    chk("R2 defer push", int'(defer_count), 1);
    respond(0); drain();   // promotes it
    respond(0); drain();
    chk("R2 defer released", got_ord[0], 1);

    // R3 stall hold, R10 push ignored while busy
    push(0, 0, 0, 0, 50, 0);
    push(0, 0, 0, 0, 51, 0);
    rel_ready = 0;
    respond(0);
    chk("R3 valid", int'(rel_valid), 1);
    chk("R3 first", int'(rel_order), 50);
    push(1, 0, 0, 1, 77, 0);
    @(negedge clk);
    chk("R3 hold", int'(rel_order), 50);
    chk("R3 hold valid", int'(rel_valid), 1);
    drain();
    chk("R3 rest", got_ord[1], 51);
    chk("R10 push while busy", int'(defer_count) + int'(prim_count), 0);
    chk("R10 defer_nw untouched", int'(defer_nw), 0);

    // R10 priority: response beats push in the same cycle
    push(0, 0, 0, 0, 60, 0);
    @(negedge clk);
    rsp_valid = 1; push_valid = 1; push_defer = 0; push_order = 61;
    @(negedge clk);
    rsp_valid = 0; push_valid = 0;
    drain();
    chk("R10 priority count", got_n, 1);
    chk("R10 no push", int'(prim_count), 0);

    // R5 flags
    push(0, 0, 0, 0, 1, 0);
    push(0, 0, 0, 1, 2, 0);
    chk("R5 prim_nw set", int'(prim_nw), 1);
    respond(1); drain();
    chk("R5 kept nw", int'(prim_nw), 1);
    respond(0); drain();
    chk("R5 cleared", int'(prim_nw), 0);
    push(0, 0, 0, 0, 3, 0);
    push(0, 2, 0, 1, 4, 0);
    chk("R5 snoop excluded", int'(prim_nw), 0);
    respond(0); drain();

    // R6 / R7 / R8 promotion
    now = 50;
    push(0, 0, 0, 0, 10, 5);
    push(1, 0, 0, 1, 20, 100);
    push(1, 0, 0, 0, 21, 0);
    push(1, 0, 1, 0, 22, 30);
    push(1, 0, 0, 0, 23, 0);
    chk("R5 defer_nw", int'(defer_nw), 1);
    respond(0); drain();
    chk("R6 released", got_ord[0], 10);
    chk("R6 prim after", int'(prim_count), 2);
    chk("R6 defer after", int'(defer_count), 2);
    chk("R8 order", int'(entry_order), 20);
    chk("R8 ready head", int'(entry_ready), 100);
    chk("R5 after promote", int'({prim_nw, defer_nw}), 2);
    respond(0); drain();
    chk("R6 second", got_ord[1], 21);
    chk("R7 cmo alone", int'(prim_count), 1);
    chk("R7 cmo defer", int'(defer_count), 1);
    chk("R8 ready now", int'(entry_ready), 50);
    chk("R8 cmo order", int'(entry_order), 22);
    now = 60;
    respond(0); drain();
    chk("R6 tail promote", int'(entry_order), 23);
    chk("R8 ready 60", int'(entry_ready), 60);
    now = 99;
    respond(0); drain();
    chk("R6 empty order", int'(entry_order), 23);
    chk("R6 empty ready", int'(entry_ready), 60);

    // R7 cmo head blocked by nonempty primary
    push(0, 0, 0, 0, 1, 0);
    push(0, 0, 0, 0, 2, 0);
    push(1, 0, 1, 0, 3, 0);
    respond(1); drain();
    chk("R7 blocked prim", int'(prim_count), 1);
    chk("R7 blocked defer", int'(defer_count), 1);
    chk("R7 order", int'(entry_order), 2);
    respond(0); drain();
    respond(0); drain();
    chk("R7 cmo last", got_ord[0], 3);

    // R9 writable promotion
    push(0, 0, 0, 0, 39, 0);
    push(1, 0, 0, 1, 40, 0);
    push(1, 0, 0, 0, 41, 0);
    post_inv = 1;
    @(negedge clk); wr_valid = 1; @(negedge clk); wr_valid = 0;
    chk("R9 blocked", int'(defer_count), 2);
    post_inv = 0;
    @(negedge clk); wr_valid = 1; @(negedge clk); wr_valid = 0;
    chk("R9 prim", int'(prim_count), 3);
    chk("R9 defer", int'(defer_count), 0);
    chk("R9 flags", int'({prim_nw, defer_nw}), 2);
    respond(0); drain();
    chk("R9 order mid", got_ord[1], 40);
    chk("R9 order tail", got_ord[2], 41);

    finish_run();
  end
endmodule